// File: doc/BRIEF.md
# Capture Event Prescaler and Source Selector

This block sits between the edge detectors and the capture register of one timer capture channel. A 2-bit selection field sets the channel's role. It can be an output, in which case it never captures. It can also be an input that takes its events from its own pin, from the neighbouring channel's pin, or from an internal trigger. The internal trigger only counts while a trigger-valid flag confirms that a trigger source has been chosen.

A prescaler field sets how many selected events must occur for each capture: 1, 2, 4 or 8. The channel enable does two things. While it is low, the prescaler is held at zero. While it is high, writes to the selection field are refused.

On each capture the block stores the running timer count in the capture register, pulses a strobe for one cycle and raises a capture flag. A capture that arrives while the previous flag is still unacknowledged also raises an overrun flag. One acknowledge input clears both flags.

Top module: `cap_channel`

## Requirements
- R1: After reset, `cap_val`, `cap_strobe`, `cap_flag`, `ovr_flag` and `sel_q` are all 0, and the prescaler count is 0.
- R2: With `sel_q` = 0 (output role), no event on any source produces a capture strobe.
- R3: With `sel_q` = 1, only `ev_own` events are counted. With `sel_q` = 2, only `ev_nbr` events are counted. Events on the other sources have no effect on strobes.
- R4: With `sel_q` = 3, an `ev_trig` event is counted only in a cycle where `trig_ok` is 1. Trigger events while `trig_ok` is 0 are ignored.
- R5: `cfg_psc` codes 0, 1, 2 and 3 give one strobe per 1, 2, 4 and 8 selected events. After enabling, the first strobe follows the Nth event, where N is the ratio.
- R6: While `chan_en` is 0, the prescaler count is held at 0 and no strobe occurs. A partial count made before a disable is discarded.
- R7: A `cfg_wr` pulse loads `cfg_sel_wdata` into `sel_q` only when `chan_en` is 0. While `chan_en` is 1, the write is ignored.
- R8: The strobe is high for exactly the one cycle after the clock edge that sampled the completing event. `cap_val` then holds the `cnt_val` of that event cycle and keeps it until the next strobe.
- R9: A strobe sets `cap_flag`. `flag_clr` clears `cap_flag` and `ovr_flag`. When a strobe and `flag_clr` fall in the same cycle, `cap_flag` ends at 1 and `ovr_flag` ends at 0.
- R10: A strobe that occurs while `cap_flag` is 1 and `flag_clr` is 0 in that cycle sets `ovr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_own | input | 1 | Filtered edge event from this channel's pin |
| ev_nbr | input | 1 | Filtered edge event from the neighbouring channel's pin |
| ev_trig | input | 1 | Internal trigger event |
| trig_ok | input | 1 | Internal trigger source is valid |
| cfg_wr | input | 1 | Write pulse for the selection field |
| cfg_sel_wdata | input | 2 | Selection value to write (0 output, 1 own, 2 neighbour, 3 trigger) |
| cfg_psc | input | PSC_BITS | Prescale code, ratio = 2^code |
| chan_en | input | 1 | Channel enable |
| flag_clr | input | 1 | Acknowledge: clears capture and overrun flags |
| cnt_val | input | CNT_W | Running timer counter value |
| sel_q | output | 2 | Current selection field |
| cap_val | output | CNT_W | Capture register |
| cap_strobe | output | 1 | One-cycle capture strobe |
| cap_flag | output | 1 | Capture pending flag |
| ovr_flag | output | 1 | Capture overrun flag |

## Verification
Two functions can land in the same cycle: a fresh capture, which sets the flag and may set the overrun, and the software acknowledge, which clears both. The bench provokes this by raising `flag_clr` in the exact cycle of a completing event while the flag is set. It expects the flag to stay at 1 with no overrun. A following capture without acknowledge must then raise the overrun. A per-clock behavioural model tracks the flags, the strobe and the captured value through every scenario.

// File: rtl/cap_chan_pkg.sv
package cap_chan_pkg;

   typedef enum logic [1:0] {
      SRC_OUTPUT = 2'd0,
      SRC_OWN    = 2'd1,
      SRC_NBR    = 2'd2,
      SRC_TRIG   = 2'd3
   } src_sel_e;

   localparam int MAX_PSC_BITS = 3;

endpackage

// File: rtl/cap_sel_reg.sv
module cap_sel_reg
   import cap_chan_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] wdata,
   input  logic       locked,
   output src_sel_e   sel
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= SRC_OUTPUT;
      end else if (wr && !locked) begin
         sel <= src_sel_e'(wdata);
      end
   end

endmodule

// File: rtl/cap_src_select.sv
module cap_src_select
   import cap_chan_pkg::*;
#(
   parameter bit TRIG_GATE = 1'b1
) (
   input  src_sel_e sel,
   input  logic     ev_own,
   input  logic     ev_nbr,
   input  logic     ev_trig,
   input  logic     trig_ok,
   output logic     ev_sel
);

   logic trig_eff;

   generate
      if (TRIG_GATE) begin : g_trig_gated
         assign trig_eff = ev_trig & trig_ok;
      end else begin : g_trig_raw
         logic unused_ok;
         assign unused_ok = trig_ok;
         assign trig_eff  = ev_trig;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SRC_OWN:  ev_sel = ev_own;
         SRC_NBR:  ev_sel = ev_nbr;
         SRC_TRIG: ev_sel = trig_eff;
         default:  ev_sel = 1'b0;
      endcase
   end

endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
   parameter int PSC_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                ev,
   input  logic [PSC_BITS-1:0] code,
   output logic                fire
);

   localparam int CW = (1 << PSC_BITS) - 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      lim  = CW'((32'd1 << code) - 32'd1);
      fire = en && ev && (cnt >= lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (ev) begin
         if (cnt >= lim) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

endmodule

// File: rtl/cap_store.sv
module cap_store #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_strobe,
   output logic             cap_flag,
   output logic             ovr_flag
);

   logic overrun_now;

   assign overrun_now = fire && cap_flag && !flag_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val    <= '0;
         cap_strobe <= 1'b0;
         cap_flag   <= 1'b0;
         ovr_flag   <= 1'b0;
      end else begin
         cap_strobe <= fire;
         if (fire) begin
            cap_val <= cnt_val;
         end
         if (fire) begin
            cap_flag <= 1'b1;
         end else if (flag_clr) begin
            cap_flag <= 1'b0;
         end
         if (overrun_now) begin
            ovr_flag <= 1'b1;
         end else if (flag_clr) begin
            ovr_flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cap_channel.sv
module cap_channel
   import cap_chan_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int PSC_BITS  = 2,
   parameter bit TRIG_GATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_own,
   input  logic                ev_nbr,
   input  logic                ev_trig,
   input  logic                trig_ok,
   input  logic                cfg_wr,
   input  logic [1:0]          cfg_sel_wdata,
   input  logic [PSC_BITS-1:0] cfg_psc,
   input  logic                chan_en,
   input  logic                flag_clr,
   input  logic [CNT_W-1:0]    cnt_val,
   output logic [1:0]          sel_q,
   output logic [CNT_W-1:0]    cap_val,
   output logic                cap_strobe,
   output logic                cap_flag,
   output logic                ovr_flag
);

   generate
      if (CNT_W < 1 || CNT_W > 64) begin : g_bad_cnt_w
         $error("cap_channel: CNT_W must lie in 1..64");
      end
      if (PSC_BITS < 1 || PSC_BITS > MAX_PSC_BITS) begin : g_bad_psc_bits
         $error("cap_channel: PSC_BITS must lie in 1..3");
      end
   endgenerate

   src_sel_e sel;
   logic     ev_sel;
   logic     fire;

   cap_sel_reg u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (cfg_wr),
      .wdata  (cfg_sel_wdata),
      .locked (chan_en),
      .sel    (sel)
   );

   cap_src_select #(.TRIG_GATE(TRIG_GATE)) u_src (
      .sel     (sel),
      .ev_own  (ev_own),
      .ev_nbr  (ev_nbr),
      .ev_trig (ev_trig),
      .trig_ok (trig_ok),
      .ev_sel  (ev_sel)
   );

   cap_prescaler #(.PSC_BITS(PSC_BITS)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (chan_en),
      .ev    (ev_sel),
      .code  (cfg_psc),
      .fire  (fire)
   );

   cap_store #(.CNT_W(CNT_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .cnt_val    (cnt_val),
      .flag_clr   (flag_clr),
      .cap_val    (cap_val),
      .cap_strobe (cap_strobe),
      .cap_flag   (cap_flag),
      .ovr_flag   (ovr_flag)
   );

   assign sel_q = sel;

endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
   parameter int CNT_W    = 16,
   parameter int PSC_BITS = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ev_own,
   input logic                ev_nbr,
   input logic                ev_trig,
   input logic                trig_ok,
   input logic                cfg_wr,
   input logic [1:0]          cfg_sel_wdata,
   input logic [PSC_BITS-1:0] cfg_psc,
   input logic                chan_en,
   input logic                flag_clr,
   input logic [CNT_W-1:0]    cnt_val,
   input logic [1:0]          sel_q,
   input logic [CNT_W-1:0]    cap_val,
   input logic                cap_strobe,
   input logic                cap_flag,
   input logic                ovr_flag
);

   AST_OUTPUT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == 2'd0) |=> !cap_strobe); // R2

   AST_OWN_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && sel_q == 2'd1 && cfg_psc == '0 && ev_own) |=> cap_strobe); // R3

   AST_NBR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && sel_q == 2'd2 && cfg_psc == '0 && ev_nbr) |=> cap_strobe); // R3

   AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == 2'd3 && !trig_ok) |=> !cap_strobe); // R4

   AST_TRIG_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && sel_q == 2'd3 && cfg_psc == '0 && ev_trig && trig_ok) |=> cap_strobe); // R4

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !cap_strobe); // R6

   AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en |=> $stable(sel_q)); // R7

   AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en && cfg_wr) |=> (sel_q == $past(cfg_sel_wdata))); // R7

   AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |-> (cap_val == $past(cnt_val))); // R8

   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_strobe |-> $stable(cap_val)); // R8

   AST_FLAG_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |-> cap_flag); // R9

   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_strobe && $past(cap_flag) && !$past(flag_clr)) |-> ovr_flag); // R10

   AST_OVERRUN_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> (cap_strobe && $past(cap_flag))); // R10

endmodule

bind cap_channel cap_channel_chk #(.CNT_W(CNT_W), .PSC_BITS(PSC_BITS)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .ev_own        (ev_own),
   .ev_nbr        (ev_nbr),
   .ev_trig       (ev_trig),
   .trig_ok       (trig_ok),
   .cfg_wr        (cfg_wr),
   .cfg_sel_wdata (cfg_sel_wdata),
   .cfg_psc       (cfg_psc),
   .chan_en       (chan_en),
   .flag_clr      (flag_clr),
   .cnt_val       (cnt_val),
   .sel_q         (sel_q),
   .cap_val       (cap_val),
   .cap_strobe    (cap_strobe),
   .cap_flag      (cap_flag),
   .ovr_flag      (ovr_flag)
);

// File: tb/cap_channel_tb_top.sv
`timescale 1ns/1ps
module cap_channel_tb_top;

   localparam int CNT_W = 16;
   localparam int PSC_BITS = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ev_own = 1'b0, ev_nbr = 1'b0, ev_trig = 1'b0, trig_ok = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [1:0]       cfg_sel_wdata = 2'd0;
   logic [1:0]       cfg_psc = 2'd0;
   logic             chan_en = 1'b0;
   logic             flag_clr = 1'b0;
   logic [CNT_W-1:0] cnt_val = '0;
   logic [1:0]       sel_q;
   logic [CNT_W-1:0] cap_val;
   logic             cap_strobe, cap_flag, ovr_flag;

   int checks = 0;
   int fails = 0;
   int n_strobe = 0;
   int cyc = 0;
   bit done = 1'b0;

   // reference model state
   int  m_sel = 0, m_cnt = 0;
   bit  m_strobe = 0, m_flag = 0, m_ovr = 0;
   logic [CNT_W-1:0] m_val = '0;

   always #10 clk = ~clk;

   cap_channel #(.CNT_W(CNT_W), .PSC_BITS(PSC_BITS), .TRIG_GATE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .ev_own(ev_own), .ev_nbr(ev_nbr), .ev_trig(ev_trig),
      .trig_ok(trig_ok), .cfg_wr(cfg_wr), .cfg_sel_wdata(cfg_sel_wdata), .cfg_psc(cfg_psc),
      .chan_en(chan_en), .flag_clr(flag_clr), .cnt_val(cnt_val), .sel_q(sel_q),
      .cap_val(cap_val), .cap_strobe(cap_strobe), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      bit ev, fire, nov;
      if (!rst_n) begin
         m_sel = 0; m_cnt = 0; m_strobe = 0; m_flag = 0; m_ovr = 0; m_val = '0;
      end else begin
         case (m_sel)
            1: ev = ev_own;
            2: ev = ev_nbr;
            3: ev = ev_trig && trig_ok;
            default: ev = 0;
         endcase
         fire = 0;
         if (!chan_en) m_cnt = 0;
         else if (ev) begin
            m_cnt++;
            if (m_cnt >= (1 << cfg_psc)) begin
               fire = 1;
               m_cnt = 0;
            end
         end
         nov = fire && m_flag && !flag_clr;
         m_strobe = fire;
         if (fire) m_val = cnt_val;
         if (fire) m_flag = 1; else if (flag_clr) m_flag = 0;
         if (nov) m_ovr = 1; else if (flag_clr) m_ovr = 0;
         if (cfg_wr && !chan_en) m_sel = int'(cfg_sel_wdata);
      end
   end

   // compare a quarter period after every rising edge
   always @(posedge clk) begin
      #5;
      if (!done) begin
         if (cap_strobe) n_strobe++;
         chk(cap_strobe == m_strobe, "R8", "model strobe", cap_strobe, m_strobe);
         chk(cap_val == m_val, "R8", "model cap_val", cap_val, m_val);
         chk(cap_flag == m_flag, "R9", "model cap_flag", cap_flag, m_flag);
         chk(ovr_flag == m_ovr, "R10", "model ovr_flag", ovr_flag, m_ovr);
         chk(int'(sel_q) == m_sel, "R7", "model sel_q", sel_q, m_sel);
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic edge_n();
      @(negedge clk);
      cnt_val = cnt_val + 16'd13;
   endtask

   task automatic setup(input int sel, input int psc);
      edge_n();
      chan_en = 0; cfg_wr = 1; cfg_sel_wdata = 2'(sel); cfg_psc = 2'(psc); flag_clr = 1;
      edge_n();
      cfg_wr = 0; flag_clr = 0; chan_en = 1;
      edge_n();
      n_strobe = 0;
   endtask

   task automatic pulses(input int k, input bit o, input bit n, input bit t);
      for (int i = 0; i < k; i++) begin
         edge_n();
         ev_own = o; ev_nbr = n; ev_trig = t;
      end
      edge_n();
      ev_own = 0; ev_nbr = 0; ev_trig = 0;
      edge_n();
   endtask

   initial begin
      logic [CNT_W-1:0] v;
      repeat (3) edge_n();
      rst_n = 1;
      edge_n();
      // R1 reset state
      chk(cap_val == 0 && !cap_strobe && !cap_flag && !ovr_flag && sel_q == 0,
          "R1", "reset outputs", {cap_val, cap_strobe, cap_flag, ovr_flag, sel_q}, 0);

      // R2 output role
      setup(0, 0);
      pulses(5, 1, 1, 1);
      chk(n_strobe == 0, "R2", "strobes in output role", n_strobe, 0);

      // R3 own and neighbour mapping
      setup(1, 0);
      pulses(3, 1, 0, 0);
      chk(n_strobe == 3, "R3", "own events with sel 1", n_strobe, 3);
      n_strobe = 0;
      pulses(3, 0, 1, 1);
      chk(n_strobe == 0, "R3", "foreign events with sel 1", n_strobe, 0);
      setup(2, 0);
      pulses(3, 0, 1, 0);
      chk(n_strobe == 3, "R3", "neighbour events with sel 2", n_strobe, 3);
      n_strobe = 0;
      pulses(3, 1, 0, 1);
      chk(n_strobe == 0, "R3", "foreign events with sel 2", n_strobe, 0);

      // R4 trigger gating
      setup(3, 0);
      trig_ok = 0;
      pulses(4, 1, 1, 1);
      chk(n_strobe == 0, "R4", "trigger while invalid", n_strobe, 0);
      trig_ok = 1;
      pulses(4, 0, 0, 1);
      chk(n_strobe == 4, "R4", "trigger while valid", n_strobe, 4);
      trig_ok = 0;

      // R5 ratios and first capture on Nth event
      for (int c = 0; c < 4; c++) begin
         int nr;
         nr = 1 << c;
         setup(1, c);
         if (nr > 1) begin
            pulses(nr - 1, 1, 0, 0);
            chk(n_strobe == 0, "R5", "before Nth event", n_strobe, 0);
         end
         pulses(1, 1, 0, 0);
         chk(n_strobe == 1, "R5", "at Nth event", n_strobe, 1);
         pulses(nr, 1, 0, 0);
         chk(n_strobe == 2, "R5", "after 2N events", n_strobe, 2);
      end

      // R6 disable resets prescaler
      setup(1, 2);
      pulses(3, 1, 0, 0);
      chk(n_strobe == 0, "R6", "partial count", n_strobe, 0);
      edge_n(); chan_en = 0;
      pulses(5, 1, 0, 0);
      chk(n_strobe == 0, "R6", "events while disabled", n_strobe, 0);
      edge_n(); chan_en = 1;
      pulses(1, 1, 0, 0);
      chk(n_strobe == 0, "R6", "partial count discarded", n_strobe, 0);
      pulses(3, 1, 0, 0);
      chk(n_strobe == 1, "R6", "fresh count of four", n_strobe, 1);

      // R7 selection write protection
      setup(1, 0);
      edge_n(); cfg_wr = 1; cfg_sel_wdata = 2'd2;
      edge_n(); cfg_wr = 0;
      edge_n();
      chk(sel_q == 2'd1, "R7", "write while enabled", sel_q, 1);
      edge_n(); chan_en = 0; cfg_wr = 1; cfg_sel_wdata = 2'd2;
      edge_n(); cfg_wr = 0;
      edge_n();
      chk(sel_q == 2'd2, "R7", "write while disabled", sel_q, 2);

      // R8 captured value and strobe width
      setup(1, 0);
      edge_n(); ev_own = 1; v = cnt_val;
      edge_n(); ev_own = 0;
      chk(cap_strobe == 1'b1, "R8", "strobe after event", cap_strobe, 1);
      chk(cap_val == v, "R8", "captured count", cap_val, v);
      edge_n();
      chk(cap_strobe == 1'b0, "R8", "strobe one cycle", cap_strobe, 0);
      chk(cap_val == v, "R8", "capture held", cap_val, v);

      // R9 / R10 capture and acknowledge in the same cycle
      edge_n(); ev_own = 1; flag_clr = 1;
      edge_n(); ev_own = 0; flag_clr = 0;
      edge_n();
      chk(cap_flag == 1'b1, "R9", "flag after strobe+clear", cap_flag, 1);
      chk(ovr_flag == 1'b0, "R10", "no overrun when acknowledged", ovr_flag, 0);
      edge_n(); ev_own = 1;
      edge_n(); ev_own = 0;
      edge_n();
      chk(ovr_flag == 1'b1, "R10", "overrun on unacknowledged flag", ovr_flag, 1);
      edge_n(); flag_clr = 1;
      edge_n(); flag_clr = 0;
      edge_n();
      chk(cap_flag == 1'b0, "R9", "flag cleared", cap_flag, 0);
      chk(ovr_flag == 1'b0, "R9", "overrun cleared", ovr_flag, 0);

      repeat (2) edge_n();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule